// File: doc/BRIEF.md
# Pulse-Position IR Frame Transmitter

This block converts a 16-bit address and an 8-bit data byte into an infrared remote-control frame. The frame is sent as pulse-position-modulated bursts of a roughly 38 kHz carrier. All timing is counted in ticks of a clock-enable input, which is normally a one-microsecond strobe, so every segment length is a parameter given in ticks. A start strobe launches a complete frame. The address and data are captured when the strobe is accepted.

Frames begin on a fixed slot grid of nominally 108 ms. If the held flag is still high when a slot ends, the next slot carries a short repeat frame instead of a second complete frame. When held drops, the frame in progress finishes and no further frame is started. An active-low busy indicator covers the whole transmission, so it can drive a transmit lamp.

Top module: `ir_ppm_tx`

## Requirements
- R1: An accepted start begins a full frame. The frame opens with a carrier burst of HDR_T ticks, followed by a silent space of GAP_T ticks.
- R2: A full frame carries 32 bits, least significant bit first: address bits 0..15, then data bits 0..7, then the bitwise complement of data bits 0..7.
- R3: Every bit opens with a MARK_T burst. From one bit's burst start to the next burst start is ZERO_T ticks for a 0 and ONE_T ticks for a 1.
- R4: A closing MARK_T burst follows the last bit of a full frame. After it the drive output stays low.
- R5: Consecutive frames of one transmission start exactly SLOT_T ticks apart. The first frame is always a full frame, whatever the held flag does.
- R6: If held_i is high when a slot ends, a repeat frame starts at once. A repeat frame is an HDR_T burst, an RPT_GAP_T space and a MARK_T burst.
- R7: If held_i is low when a slot ends, no new frame starts. Dropping held_i never cuts short the frame in progress.
- R8: During a burst, the drive output is high for the first CAR_ON_T ticks of every CAR_PER_T-tick carrier period. The carrier phase restarts at each burst start. Outside bursts the drive output is low.
- R9: busy_no goes low on the clock edge that accepts a start. It stays low until the last slot of the transmission ends, and is high at all other times.
- R10: A start strobe that arrives while busy_no is low is ignored. The frame in progress keeps the address and data captured at its own start.
- R11: Timing advances only on cycles with tick_i high. With tick_i low, neither output changes, except for the acceptance of a start while idle.
- R12: During and after reset the drive output is low and busy_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable; one tick per timing unit |
| start_i | input | 1 | Start strobe; accepted only while idle |
| held_i | input | 1 | Key-held flag, sampled at each slot end |
| addr_i | input | 16 | Address, captured at start |
| data_i | input | 8 | Data byte, captured at start |
| ir_drive_o | output | 1 | Modulated carrier drive |
| busy_no | output | 1 | Transmission indicator, low while busy |

## Verification
Two decisions coincide on one tick: the slot timer expiring and the sequencer choosing between a repeat frame and idle. The bench drops held_i inside a repeat header, so the frame completes and the next slot end finds held low. It also keeps held high across slot ends. A scoreboard then compares every burst's start-to-start distance and carrier-on count, and the busy-low duration must equal a whole number of slots. A second coincidence is a stray start strobe that lands on an active tick mid-frame. It must leave the burst stream unchanged, which the scoreboard would catch as an extra or shifted burst.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_GAP,
    ST_MARK,
    ST_SPACE,
    ST_TAIL,
    ST_DONE
  } tx_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ir_frame_seq.sv
module ir_frame_seq
  import ir_tx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HDR_T     = 9000,
  parameter int unsigned GAP_T     = 4500,
  parameter int unsigned RPT_GAP_T = 2240,
  parameter int unsigned MARK_T    = 560,
  parameter int unsigned ZERO_T    = 1120,
  parameter int unsigned ONE_T     = 2240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              held_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              slot_end_i,
  output tx_state_e         state_o,
  output logic              env_o,
  output logic              launch_o
);

  localparam int unsigned PAY_W = ADDR_W + 2 * DATA_W;
  localparam int unsigned MAX_T = max_u(max_u(HDR_T, GAP_T),
                                        max_u(max_u(RPT_GAP_T, MARK_T), max_u(ZERO_T, ONE_T)));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam int unsigned IDX_W = $clog2(PAY_W);

  tx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   seg_last;
  logic [PAY_W-1:0]   pay_q;
  logic [PAY_W-1:0]   pay_load;
  logic [IDX_W-1:0]   idx_q;
  logic               rpt_q;
  logic               seg_done;

  // bit 0 goes out first: address, data, then inverted data
  assign pay_load = {~data_i, data_i, addr_i};

  always_comb begin
    case (state_q)
      ST_HDR:   seg_last = CNT_W'(HDR_T - 1);
      ST_GAP:   seg_last = rpt_q ? CNT_W'(RPT_GAP_T - 1) : CNT_W'(GAP_T - 1);
      ST_MARK:  seg_last = CNT_W'(MARK_T - 1);
      ST_TAIL:  seg_last = CNT_W'(MARK_T - 1);
      ST_SPACE: seg_last = pay_q[0] ? CNT_W'(ONE_T - MARK_T - 1) : CNT_W'(ZERO_T - MARK_T - 1);
      default:  seg_last = '0;
    endcase
  end

  assign seg_done = tick_i && (cnt_q == seg_last);
  assign launch_o = ((state_q == ST_IDLE) && start_i) ||
                    ((state_q == ST_DONE) && slot_end_i && held_i);
  assign env_o    = (state_q == ST_HDR) || (state_q == ST_MARK) || (state_q == ST_TAIL);
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pay_q   <= '0;
      idx_q   <= '0;
      rpt_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pay_q   <= pay_load;
            idx_q   <= IDX_W'(PAY_W - 1);
            rpt_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_HDR;
          end
        end
        ST_DONE: begin
          if (slot_end_i) begin
            if (held_i) begin
              rpt_q   <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_HDR;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          if (tick_i) begin
            if (!seg_done) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              case (state_q)
                ST_HDR:  state_q <= ST_GAP;
                ST_GAP:  state_q <= rpt_q ? ST_TAIL : ST_MARK;
                ST_MARK: state_q <= ST_SPACE;
                ST_SPACE: begin
                  pay_q <= pay_q >> 1;
                  if (idx_q == '0) begin
                    state_q <= ST_TAIL;
                  end else begin
                    idx_q   <= idx_q - 1'b1;
                    state_q <= ST_MARK;
                  end
                end
                ST_TAIL: state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ir_slot_timer.sv
module ir_slot_timer #(
  parameter int unsigned SLOT_T = 108000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  input  logic launch_i,
  output logic slot_end_o
);

  localparam int unsigned SL_W = $clog2(SLOT_T);

  logic [SL_W-1:0] cnt_q;

  assign slot_end_o = active_i && tick_i && (cnt_q == SL_W'(SLOT_T - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (launch_i || slot_end_o) begin
      cnt_q <= '0;
    end else if (active_i && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ir_carrier.sv
module ir_carrier #(
  parameter int unsigned PER_T = 26,
  parameter int unsigned ON_T  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic env_i,
  output logic drive_o
);

  localparam int unsigned PH_W = (PER_T > 1) ? $clog2(PER_T) : 1;

  logic [PH_W-1:0] ph_q;

  // phase held at zero between bursts so each burst opens on a high slice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (!env_i) begin
      ph_q <= '0;
    end else if (tick_i) begin
      ph_q <= (ph_q == PH_W'(PER_T - 1)) ? '0 : ph_q + 1'b1;
    end
  end

  assign drive_o = env_i && (ph_q < PH_W'(ON_T));

endmodule

// File: rtl/ir_ppm_tx.sv
module ir_ppm_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HDR_T     = 9000,
  parameter int unsigned GAP_T     = 4500,
  parameter int unsigned RPT_GAP_T = 2240,
  parameter int unsigned MARK_T    = 560,
  parameter int unsigned ZERO_T    = 1120,
  parameter int unsigned ONE_T     = 2240,
  parameter int unsigned SLOT_T    = 108000,
  parameter int unsigned CAR_PER_T = 26,
  parameter int unsigned CAR_ON_T  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              held_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ir_drive_o,
  output logic              busy_no
);

  tx_state_e state;
  logic      env;
  logic      launch;
  logic      slot_end;
  logic      active;

  assign active  = (state != ST_IDLE);
  assign busy_no = ~active;

  ir_frame_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HDR_T    (HDR_T),
    .GAP_T    (GAP_T),
    .RPT_GAP_T(RPT_GAP_T),
    .MARK_T   (MARK_T),
    .ZERO_T   (ZERO_T),
    .ONE_T    (ONE_T)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .held_i    (held_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .slot_end_i(slot_end),
    .state_o   (state),
    .env_o     (env),
    .launch_o  (launch)
  );

  ir_slot_timer #(
    .SLOT_T(SLOT_T)
  ) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .active_i  (active),
    .launch_i  (launch),
    .slot_end_o(slot_end)
  );

  ir_carrier #(
    .PER_T(CAR_PER_T),
    .ON_T (CAR_ON_T)
  ) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .env_i  (env),
    .drive_o(ir_drive_o)
  );

endmodule

// File: rtl/ir_ppm_tx_chk.sv
module ir_ppm_tx_chk
  import ir_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tick_i,
  input logic      start_i,
  input logic      ir_drive_o,
  input logic      busy_no,
  input logic      env_i,
  input logic      slot_end_i,
  input tx_state_e state_i
);

  a_r8_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no |-> !ir_drive_o);

  a_r9_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_no) |=> !busy_no);

  a_r1_start_opens_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_no) |=> env_i);

  a_r11_frozen_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !busy_no) |=> ($stable(ir_drive_o) && $stable(busy_no)));

  a_r5_slot_ends_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_i |-> (state_i == ST_DONE));

  a_r8_burst_opens_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(env_i) |-> ir_drive_o);

endmodule

bind ir_ppm_tx ir_ppm_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .ir_drive_o(ir_drive_o),
  .busy_no   (busy_no),
  .env_i     (env),
  .slot_end_i(slot_end),
  .state_i   (state)
);

// File: tb/tb_ir_ppm_tx.sv
module tb_ir_ppm_tx;

  localparam int HDR  = 36;
  localparam int GAP  = 18;
  localparam int RPT  = 18;
  localparam int MRK  = 6;
  localparam int ZRO  = 12;
  localparam int ONE  = 24;
  localparam int SLOT = 900;
  localparam int PER  = 3;
  localparam int ON   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic        held = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        drive;
  logic        busy_n;

  ir_ppm_tx #(
    .HDR_T(HDR), .GAP_T(GAP), .RPT_GAP_T(RPT), .MARK_T(MRK), .ZERO_T(ZRO),
    .ONE_T(ONE), .SLOT_T(SLOT), .CAR_PER_T(PER), .CAR_ON_T(ON)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .held_i(held),
    .addr_i(addr), .data_i(data), .ir_drive_o(drive), .busy_no(busy_n)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  int tick_ph = 0;
  bit start_req = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0;

  // tick and start generation: start only goes out on a tick cycle
  always @(negedge clk) begin
    if (tick_ph + 1 >= tick_div) tick_ph = 0;
    else tick_ph = tick_ph + 1;
    tick  = (tick_ph == 0);
    start = 1'b0;
    if (start_req && tick) begin
      start     = 1'b1;
      addr      = req_addr;
      data      = req_data;
      start_req = 1'b0;
    end
  end

  typedef struct {
    int    gap;
    int    hi;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   last_off = 0;

  function automatic void push(int g, int h, string t);
    exp_t e;
    e.gap = (g < 0) ? -1 : g * tick_div;
    e.hi  = h * tick_div;
    e.tag = t;
    exp_q.push_back(e);
  endfunction

  function automatic void chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endfunction

  task automatic expect_full(input logic [15:0] a, input logic [7:0] d);
    logic [31:0] p;
    int off;
    int per;
    p = {~d, d, a};
    push(-1, HDR / PER * ON, "R1 R8");
    off = HDR + GAP;
    per = HDR + GAP;
    for (int i = 0; i < 32; i++) begin
      push(per, MRK / PER * ON, (i == 0) ? "R1" : "R2 R3");
      per = p[i] ? ONE : ZRO;
      off = off + per;
    end
    push(per, MRK / PER * ON, "R4");
    last_off = off;
  endtask

  task automatic expect_repeat();
    push(SLOT - last_off, HDR / PER * ON, "R5");
    push(HDR + RPT, MRK / PER * ON, "R6");
    last_off = HDR + RPT;
  endtask

  // monitor: rebuild bursts from the carrier and score them
  int cyc = 0;
  int last_start = 0;
  int cur_gap = 0;
  int hi_cnt = 0;
  int low_run = 0;
  int busy_cnt = 0;
  bit in_burst = 1'b0;

  task automatic finish_burst(int g, int h);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R7: unexpected burst gap=%0d hi=%0d expected none", g, h);
    end else begin
      e = exp_q.pop_front();
      if ((e.gap >= 0 && e.gap != g) || e.hi != h) begin
        errors++;
        $display("FAIL %s: burst gap=%0d hi=%0d expected gap=%0d hi=%0d",
                 e.tag, g, h, e.gap, e.hi);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!busy_n) busy_cnt++;
    if (drive) begin
      if (!in_burst) begin
        in_burst   = 1'b1;
        hi_cnt     = 1;
        low_run    = 0;
        cur_gap    = cyc - last_start;
        last_start = cyc;
      end else begin
        hi_cnt++;
        low_run = 0;
      end
    end else if (in_burst) begin
      low_run++;
      if (low_run == (PER - ON) * tick_div + 1) begin
        in_burst = 1'b0;
        finish_burst(cur_gap, hi_cnt);
      end
    end
  end

  task automatic launch(input logic [15:0] a, input logic [7:0] d);
    busy_cnt  = 0;
    req_addr  = a;
    req_data  = d;
    start_req = 1'b1;
    while (start_req) @(posedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!busy_n);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(drive == 1'b0, "R12 drive in reset", drive, 0);
    chk(busy_n == 1'b1, "R12 busy in reset", busy_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(drive == 1'b0, "R12 drive after reset", drive, 0);
    chk(busy_n == 1'b1, "R12 busy after reset", busy_n, 1);

    // S1: single full frame, stray start mid-frame
    held = 1'b0;
    expect_full(16'hA55A, 8'h3C);
    launch(16'hA55A, 8'h3C);
    repeat (100) @(negedge clk);
    req_addr  = 16'h0F0F;
    req_data  = 8'h81;
    start_req = 1'b1;
    while (start_req) @(posedge clk);
    wait_idle();
    chk(exp_q.size() == 0, "R10 R4 stray start, all bursts seen", exp_q.size(), 0);
    chk(busy_cnt == SLOT, "R9 busy one slot", busy_cnt, SLOT);

    // S2: held across two slot ends, dropped inside second repeat header
    held = 1'b1;
    expect_full(16'h00FF, 8'h5A);
    expect_repeat();
    expect_repeat();
    launch(16'h00FF, 8'h5A);
    repeat (2 * SLOT + 20) @(negedge clk);
    held = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R6 R7 repeats complete", exp_q.size(), 0);
    chk(busy_cnt == 3 * SLOT, "R9 busy three slots", busy_cnt, 3 * SLOT);

    // S3: field extremes
    expect_full(16'h0000, 8'h00);
    launch(16'h0000, 8'h00);
    wait_idle();
    chk(exp_q.size() == 0, "R2 R3 all-zero fields", exp_q.size(), 0);
    expect_full(16'hFFFF, 8'hFF);
    launch(16'hFFFF, 8'hFF);
    wait_idle();
    chk(exp_q.size() == 0, "R2 R3 all-one fields", exp_q.size(), 0);

    // S4: tick every other cycle, one repeat
    tick_div = 2;
    repeat (4) @(negedge clk);
    held = 1'b1;
    expect_full(16'h1234, 8'hC5);
    expect_repeat();
    launch(16'h1234, 8'hC5);
    repeat (2 * SLOT + 30) @(negedge clk);
    held = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R11 half-rate ticks", exp_q.size(), 0);
    chk(busy_cnt == 2 * SLOT * 2, "R11 R9 busy at half rate", busy_cnt, 2 * SLOT * 2);
    tick_div = 1;
    repeat (4) @(negedge clk);

    // S5: held released before first slot end
    held = 1'b1;
    expect_full(16'hBEEF, 8'h01);
    launch(16'hBEEF, 8'h01);
    repeat (300) @(negedge clk);
    held = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R5 R7 early release full frame", exp_q.size(), 0);
    chk(busy_cnt == SLOT, "R5 busy one slot", busy_cnt, SLOT);
    chk(drive == 1'b0, "R8 idle drive low", drive, 0);

    summary();
  end

endmodule